// File: doc/BRIEF.md
# Signed Halfword-Divisor Divide Unit

This execution unit carries out a register-to-register divide in which the divisor is only a halfword. The unit receives a 16-bit instruction word together with the contents of both source registers. It decodes the two register indices from fixed fields of the instruction. The low 16 bits of the first operand are sign-extended to form the divisor. The dividend is the full 32-bit second operand. The unit returns a 32-bit signed quotient, the destination register index, and three condition flags (zero, sign, overflow) with one write strobe.

A single-cycle start request launches the operation. Ordinary operands go through a restoring divider. This divider works on magnitudes and produces one quotient bit per clock, and the sign is corrected at the end. Two operand patterns have a fixed result: a zero divisor, and the most negative dividend divided by minus one. Both bypass the loop, finish after one cycle and set overflow. No remainder is produced. The register file, instruction fetch and the rest of the status word are the job of the surrounding pipeline.

Top module: `hdiv_unit`

## Requirements
- R1: `srcAIdx` equals instruction bits [4:0], `srcBIdx` equals bits [15:11], and on completion `destIdx` equals the bits [15:11] of the accepted instruction.
- R2: The divisor is `srcAData[15:0]` sign-extended to 32 bits, and `srcAData[31:16]` has no effect on the result.
- R3: For operands that are not special cases, `quotient` is the signed quotient of `srcBData` by the divisor, truncated toward zero, and `flagOvf` is 0.
- R4: A divisor of zero gives `quotient` 0 with `flagOvf` 1, and `done` rises one cycle after the start.
- R5: A divisor of minus one with a dividend of 0x80000000 gives `quotient` 0x80000000 with `flagOvf` 1, and `done` rises one cycle after the start.
- R6: When `done` is high, `flagZero` is 1 exactly when `quotient` is zero, and `flagSign` equals `quotient[31]`.
- R7: A divide that is not a special case raises `done` 33 cycles after the start cycle (32 quotient steps plus the accept cycle).
- R8: `done` is high for exactly one cycle per accepted operation, and `flagWe` equals `done`.
- R9: A start request while `busy` is high is ignored: it changes neither the result nor the completion time of the operation in flight.
- R10: An active-high synchronous reset returns the unit to idle, with `busy`, `done` and `flagWe` low and no later completion of the interrupted operation.
- R11: `pcIncr` is 2, the instruction length in bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start pulse, accepted only while idle |
| instrWord | input | 16 | Instruction word holding both register indices |
| srcAData | input | 32 | First source register; its low half is the divisor |
| srcBData | input | 32 | Second source register; the dividend |
| srcAIdx | output | 5 | Decoded first register index |
| srcBIdx | output | 5 | Decoded second register index |
| busy | output | 1 | High from acceptance until the cycle after done |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the latest completed divide |
| destIdx | output | 5 | Register to be written with the quotient |
| flagZero | output | 1 | Quotient is zero |
| flagSign | output | 1 | Quotient bit 31 |
| flagOvf | output | 1 | Divide-by-zero or overflow case |
| flagWe | output | 1 | Write strobe for the three flags |
| pcIncr | output | 3 | Next-PC increment |

## Verification
The assertions check properties on every cycle. Done is a single-cycle pulse. The counter advances steadily through the iteration window. A special case completes on the next cycle with overflow set. The partial remainder stays below the divisor magnitude. The destination index holds steady while the loop runs. Reset forces the unit idle. Only the bench scenarios can show that the quotient value is right for each sign combination, including truncation toward zero and the wide-dividend extremes. They also show that the upper divisor half is ignored, and that a start pulse in the middle of an operation or a reset leaves no trace in later results.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } hdivState_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic loadIter;     // capture magnitudes and start the loop
    logic loadSpecial;  // capture the fixed result of a special case
    logic step;         // one restoring-division step
    logic finish;       // last step: write the sign-corrected quotient
  } hdivStrobe_t;

endpackage

// File: rtl/hdiv_ctrl.sv
module hdiv_ctrl
  import hdiv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        specialCase,
  output hdivStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  hdivState_e state, nextState;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (specialCase) begin
            strobe.loadSpecial = 1'b1;
            nextState          = ST_DONE;
          end else begin
            strobe.loadIter = 1'b1;
            nextState       = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (stepCnt == LAST_STEP) begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= nextState;
      if (strobe.loadIter) begin
        stepCnt <= '0;
      end else if (strobe.step) begin
        stepCnt <= stepCnt + CNT_W'(1);
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && stepCnt != LAST_STEP) |=>
      (state == ST_RUN && (stepCnt - $past(stepCnt)) == CNT_W'(1))); // R7
  AST_SPECIAL_FAST: assert property (@(posedge clk) disable iff (rst)
    strobe.loadSpecial |=> done); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && startReq) |=> $stable(busy) || done || $past(done)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done)); // R10

endmodule

// File: rtl/hdiv_datapath.sv
module hdiv_datapath
  import hdiv_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIVS_W    = 16,
  parameter int INSTR_W   = 16,
  parameter int IDX_W     = 5,
  parameter int SRC_A_LSB = 0,
  parameter int SRC_B_LSB = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  hdivStrobe_t        strobe,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  srcAData,
  input  logic [DATA_W-1:0]  srcBData,
  output logic               specialCase,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic [DATA_W-1:0]  resultOut,
  output logic [IDX_W-1:0]   destIdx,
  output logic               ovfOut
);

  localparam int EXT_W = DATA_W - DIVS_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // Decode and operand preparation
  logic [DATA_W-1:0] divisorExt, dvdMag, dvsMag, specialResult;
  logic              divZero, minOverMinusOne;

  assign srcAIdx    = instrWord[SRC_A_LSB +: IDX_W];
  assign srcBIdx    = instrWord[SRC_B_LSB +: IDX_W];
  assign divisorExt = {{EXT_W{srcAData[DIVS_W-1]}}, srcAData[DIVS_W-1:0]};

  assign divZero         = (divisorExt == '0);
  assign minOverMinusOne = (divisorExt == '1) && (srcBData == MOST_NEG);
  assign specialCase     = divZero || minOverMinusOne;
  assign specialResult   = divZero ? '0 : MOST_NEG;

  assign dvdMag = srcBData[DATA_W-1]   ? -srcBData   : srcBData;
  assign dvsMag = divisorExt[DATA_W-1] ? -divisorExt : divisorExt;

  // Restoring division state
  logic [DATA_W-1:0] remReg, quotReg, dvsReg, resultReg;
  logic [IDX_W-1:0]  destReg;
  logic              negReg, ovfReg;

  logic [DATA_W:0]   shiftedRem, trialDiff;
  logic              takeBit;
  logic [DATA_W-1:0] nextRem, nextQuot, fixedQuot;

  assign shiftedRem = {remReg, quotReg[DATA_W-1]};
  assign trialDiff  = shiftedRem - {1'b0, dvsReg};
  assign takeBit    = !trialDiff[DATA_W];
  assign nextRem    = takeBit ? trialDiff[DATA_W-1:0] : shiftedRem[DATA_W-1:0];
  assign nextQuot   = {quotReg[DATA_W-2:0], takeBit};
  assign fixedQuot  = negReg ? -nextQuot : nextQuot;

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg    <= '0;
      quotReg   <= '0;
      dvsReg    <= '0;
      negReg    <= 1'b0;
      resultReg <= '0;
      ovfReg    <= 1'b0;
      destReg   <= '0;
    end else begin
      if (strobe.loadIter) begin
        remReg  <= '0;
        quotReg <= dvdMag;
        dvsReg  <= dvsMag;
        negReg  <= srcBData[DATA_W-1] ^ divisorExt[DATA_W-1];
        destReg <= srcBIdx;
      end
      if (strobe.loadSpecial) begin
        resultReg <= specialResult;
        ovfReg    <= 1'b1;
        destReg   <= srcBIdx;
      end
      if (strobe.step) begin
        remReg  <= nextRem;
        quotReg <= nextQuot;
      end
      if (strobe.finish) begin
        resultReg <= fixedQuot;
        ovfReg    <= 1'b0;
      end
    end
  end

  assign resultOut = resultReg;
  assign destIdx   = destReg;
  assign ovfOut    = ovfReg;

  AST_SPECIAL_OVF: assert property (@(posedge clk) disable iff (rst)
    strobe.loadSpecial |=> ovfReg); // R5
  AST_ZERO_DIV_RESULT: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadSpecial && divZero) |=> (resultReg == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strobe.finish |=> !ovfReg); // R3
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (remReg < dvsReg)); // R3
  AST_DEST_HELD: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> $stable(destReg)); // R1

endmodule

// File: rtl/hdiv_unit.sv
module hdiv_unit
  import hdiv_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIVS_W    = 16,
  parameter int INSTR_W   = 16,
  parameter int IDX_W     = 5,
  parameter int SRC_A_LSB = 0,
  parameter int SRC_B_LSB = 11,
  parameter int PC_W      = 3,
  parameter int PC_STEP   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startReq,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  srcAData,
  input  logic [DATA_W-1:0]  srcBData,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  quotient,
  output logic [IDX_W-1:0]   destIdx,
  output logic               flagZero,
  output logic               flagSign,
  output logic               flagOvf,
  output logic               flagWe,
  output logic [PC_W-1:0]    pcIncr
);

  hdivStrobe_t strobe;
  logic        specialCase;

  hdiv_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .startReq    (startReq),
    .specialCase (specialCase),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  hdiv_datapath #(
    .DATA_W    (DATA_W),
    .DIVS_W    (DIVS_W),
    .INSTR_W   (INSTR_W),
    .IDX_W     (IDX_W),
    .SRC_A_LSB (SRC_A_LSB),
    .SRC_B_LSB (SRC_B_LSB)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .instrWord   (instrWord),
    .srcAData    (srcAData),
    .srcBData    (srcBData),
    .specialCase (specialCase),
    .srcAIdx     (srcAIdx),
    .srcBIdx     (srcBIdx),
    .resultOut   (quotient),
    .destIdx     (destIdx),
    .ovfOut      (flagOvf)
  );

  assign flagZero = (quotient == '0);
  assign flagSign = quotient[DATA_W-1];
  assign flagWe   = done;
  assign pcIncr   = PC_W'(PC_STEP);

endmodule

// File: tb/hdiv_unit_tb_top.sv
`timescale 1ns/1ps
module hdiv_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic [15:0] instrWord = '0;
  logic [31:0] srcAData = '0;
  logic [31:0] srcBData = '0;
  logic [4:0]  srcAIdx, srcBIdx, destIdx;
  logic        busy, done, flagZero, flagSign, flagOvf, flagWe;
  logic [31:0] quotient;
  logic [2:0]  pcIncr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hdiv_unit dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .instrWord(instrWord),
    .srcAData(srcAData), .srcBData(srcBData), .srcAIdx(srcAIdx),
    .srcBIdx(srcBIdx), .busy(busy), .done(done), .quotient(quotient),
    .destIdx(destIdx), .flagZero(flagZero), .flagSign(flagSign),
    .flagOvf(flagOvf), .flagWe(flagWe), .pcIncr(pcIncr)
  );

  // {divisor source, dividend, expected quotient, expected overflow}
  localparam int NVEC = 12;
  localparam logic [96:0] VEC [NVEC] = '{
    {32'h0000_0007, 32'd100,       32'h0000_000E, 1'b0},  // R3 ++
    {32'h0000_FFF9, 32'd100,       32'hFFFF_FFF2, 1'b0},  // R3 +-
    {32'h0000_0007, 32'hFFFF_FF9C, 32'hFFFF_FFF2, 1'b0},  // R3 -+
    {32'hFFFF_FFF9, 32'hFFFF_FF9C, 32'h0000_000E, 1'b0},  // R3 --
    {32'hABCD_0003, 32'h0000_0002, 32'h0000_0000, 1'b0},  // R2 upper ignored
    {32'h1234_0000, 32'h1234_5678, 32'h0000_0000, 1'b1},  // R4 zero divisor
    {32'h0000_FFFF, 32'h8000_0000, 32'h8000_0000, 1'b1},  // R5
    {32'h0000_FFFF, 32'h8000_0001, 32'h7FFF_FFFF, 1'b0},  // R3 near R5
    {32'h0000_0001, 32'h8000_0000, 32'h8000_0000, 1'b0},  // R3 by one
    {32'h0000_8000, 32'h7FFF_FFFF, 32'hFFFF_0001, 1'b0},  // R3 truncation
    {32'h0000_7FFF, 32'h8000_0000, 32'hFFFE_FFFE, 1'b0},  // R3 truncation
    {32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0}   // R3 zero dividend
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] ins, output int lat);
    while (busy) @(negedge clk);
    startReq  = 1'b1;
    srcAData  = a;
    srcBData  = b;
    instrWord = ins;
    @(negedge clk);
    startReq = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int lat;
    int doneSeen;
    logic [15:0] ins;
    logic [31:0] expQ;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy in reset", {31'b0, busy}, 32'd0);
    chk("R10 done in reset", {31'b0, done}, 32'd0);
    chk("R10 flagWe in reset", {31'b0, flagWe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R11 length
    chk("R11 pcIncr", {29'b0, pcIncr}, 32'd2);

    // R1 decode: bits [15:11]=10110, [4:0]=01101
    instrWord = 16'b10110_000010_01101;
    #1;
    chk("R1 srcAIdx", {27'b0, srcAIdx}, 32'h0D);
    chk("R1 srcBIdx", {27'b0, srcBIdx}, 32'h16);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      ins  = {5'((i * 7 + 3) % 32), 6'b000010, 5'((i * 5 + 1) % 32)};
      expQ = VEC[i][32:1];
      doOp(VEC[i][96:65], VEC[i][64:33], ins, lat);
      chk($sformatf("R3/R4/R5 quotient vec %0d", i), quotient, expQ);
      chk($sformatf("R3/R4/R5 flagOvf vec %0d", i), {31'b0, flagOvf}, {31'b0, VEC[i][0]});
      chk($sformatf("R6 flagZero vec %0d", i), {31'b0, flagZero}, {31'b0, (expQ == 0)});
      chk($sformatf("R6 flagSign vec %0d", i), {31'b0, flagSign}, {31'b0, expQ[31]});
      chk($sformatf("R1 destIdx vec %0d", i), {27'b0, destIdx}, {27'b0, ins[15:11]});
      chk($sformatf("R8 flagWe vec %0d", i), {31'b0, flagWe}, 32'd1);
      chk($sformatf("R7/R4/R5 latency vec %0d", i), lat, VEC[i][0] ? 32'd1 : 32'd33);
      @(negedge clk);
      chk($sformatf("R8 done pulse vec %0d", i), {31'b0, done}, 32'd0);
    end

    // R2: same dividend, different upper divisor halves
    doOp(32'hFFFF_0005, 32'd1000, 16'h0000, lat);
    chk("R2 upper half ones", quotient, 32'd200);
    doOp(32'h5A5A_0005, 32'd1000, 16'h0000, lat);
    chk("R2 upper half pattern", quotient, 32'd200);

    // R9: start pulse mid-operation is ignored
    while (busy) @(negedge clk);
    startReq = 1'b1; srcAData = 32'd7; srcBData = 32'd100; instrWord = 16'h4800;
    @(negedge clk);
    startReq = 1'b0;
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    startReq = 1'b1; srcAData = 32'd0; srcBData = 32'd9; instrWord = 16'hF81F;
    @(negedge clk); lat++;
    startReq = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R9 quotient unaffected", quotient, 32'd14);
    chk("R9 overflow unaffected", {31'b0, flagOvf}, 32'd0);
    chk("R9 dest unaffected", {27'b0, destIdx}, 32'd9);
    chk("R9 latency unaffected", lat, 32'd33);
    doneSeen = 0;
    repeat (40) begin @(negedge clk); if (done) doneSeen++; end
    chk("R9 no extra completion", doneSeen, 32'd0);

    // R10: reset in the middle of an operation
    startReq = 1'b1; srcAData = 32'd3; srcBData = 32'd99; instrWord = 16'h1000;
    @(negedge clk);
    startReq = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 busy after reset", {31'b0, busy}, 32'd0);
    chk("R10 done after reset", {31'b0, done}, 32'd0);
    doneSeen = 0;
    repeat (40) begin @(negedge clk); if (done) doneSeen++; end
    chk("R10 no late completion", doneSeen, 32'd0);

    // Back-to-back after reset still works
    doOp(32'h0000_FFFD, 32'd9, 16'h0800, lat);
    chk("R3 after reset quotient", quotient, 32'hFFFF_FFFD);
    chk("R1 after reset dest", {27'b0, destIdx}, 32'd1);

    finishRun();
  end

endmodule